// File: doc/BRIEF.md
# Interrupt Mask and Level Gate

This block decides, once per clock, whether the processor core should take an interrupt. It watches 32 internal request lines and one external maskable request that carries a 6-bit requested level. Each internal line passes through its own bit of a software-written enable mask. The external request passes only when its level is strictly above a programmable current level. A global enable stands in front of both paths.

Software programs the enable mask, the current level and the global enable through a small register port. The same port reads back the pending vector, which is the request lines ANDed with the mask. A handler can lower the current level below its own level to let a request at that same level pre-empt it. It can also clear mask bits so that lines of equal or lower priority stay out.

The decision is registered. It reports whether an interrupt is taken, whether the external request won, and the index of the winning internal line.

Top module: `intr_gate`

## Requirements
- R1: `pending` equals `irq_lines & mask` in the same cycle, with no register on the path. It can also be read at register address 2.
- R2: Register address 0 holds the 32-bit enable mask. Bit n set to 1 enables line n and 0 disables it. Reset clears the mask to 0.
- R3: Register address 1 is the control register: bits [5:0] hold the current level and bit 8 holds the global enable. All other bits read 0. Reset clears the register to 0. Address 3 reads 0.
- R4: A register write becomes visible on the clock edge that samples it. Before that edge, the old value stays in force.
- R5: The external request is taken only when `ext_req` is 1 and `ext_level` is strictly greater than the current level. A current level of 0 admits every nonzero level, and a current level of 63 admits none.
- R6: When any internal line is pending, an interrupt is taken. The lowest-numbered pending line wins and its number appears on `take_index`.
- R7: While the global enable is 0, nothing is taken, from either the internal lines or the external request.
- R8: When the external request and an internal line are eligible in the same cycle, the external request is presented: `take_ext` is 1 and `take_index` is 0.
- R9: `take_irq`, `take_ext` and `take_index` are registered. Each reflects the inputs and register state of the previous cycle, and reset clears all three to 0.
- R10: Writing a current level one below a running request's level admits a new request at that level. With the current level equal to the request's level, that request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Raw internal request lines |
| ext_req | input | 1 | External maskable request valid |
| ext_level | input | 6 | Level carried by the external request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| pending | output | 32 | Enabled pending internal lines |
| take_irq | output | 1 | Registered take-interrupt decision |
| take_ext | output | 1 | Registered flag: the external request won |
| take_index | output | 5 | Registered index of the winning internal line |

## Verification
The assertions check on every cycle:
- a take never happens without the global enable in the previous cycle;
- an external take always follows a strictly winning level;
- an eligible external request always wins and forces index 0;
- the reported internal index was pending and had no lower pending line.

Some behaviours only the bench's scenarios can show:
- the register map and its reset values;
- the edge at which a write takes effect;
- the full 64-by-64 sweep of current level against request level;
- same-level pre-emption after the level is lowered.

// File: rtl/intr_gate_pkg.sv
`timescale 1ns/1ps
package intr_gate_pkg;
  localparam int NLINES = 32;
  localparam int LVLW   = 6;
  localparam int DATAW  = 32;
  localparam int ADDRW  = 2;
  localparam int IDXW   = $clog2(NLINES);

  localparam logic [ADDRW-1:0] ADDR_MASK = 2'd0;
  localparam logic [ADDRW-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDRW-1:0] ADDR_PEND = 2'd2;
  localparam int GIE_BIT = 8;

  // external request is admitted only when strictly above the current level
  function automatic logic lvl_admits(input logic [LVLW-1:0] req_lvl,
                                      input logic [LVLW-1:0] cur_lvl);
    return req_lvl > cur_lvl;
  endfunction

  function automatic logic [NLINES-1:0] masked_pend(input logic [NLINES-1:0] lines,
                                                    input logic [NLINES-1:0] mask);
    return lines & mask;
  endfunction

  function automatic logic [DATAW-1:0] pack_ctrl(input logic [LVLW-1:0] lvl,
                                                 input logic gie);
    logic [DATAW-1:0] v;
    v = '0;
    v[LVLW-1:0] = lvl;
    v[GIE_BIT] = gie;
    return v;
  endfunction
endpackage

// File: rtl/intr_mask_unit.sv
`timescale 1ns/1ps
module intr_mask_unit
  import intr_gate_pkg::*;
#(
  parameter int N = NLINES
) (
  input  logic [N-1:0] lines,
  input  logic [N-1:0] mask,
  output logic [N-1:0] pend
);
  assign pend = masked_pend(lines, mask);
endmodule

// File: rtl/intr_prio_enc.sv
`timescale 1ns/1ps
module intr_prio_enc #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0]   below;
  logic [N-1:0] first;

  assign below[0] = 1'b0;
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign below[g+1] = below[g] | vec[g];
      assign first[g]   = vec[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end

  assign any = below[N];
endmodule

// File: rtl/intr_regs.sv
`timescale 1ns/1ps
module intr_regs
  import intr_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDRW-1:0]  addr,
  input  logic [DATAW-1:0]  wdata,
  input  logic [NLINES-1:0] pend,
  output logic [NLINES-1:0] mask,
  output logic [LVLW-1:0]   cur_level,
  output logic              gie,
  output logic [DATAW-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '0;
      cur_level <= '0;
      gie       <= 1'b0;
    end else if (wr) begin
      if (addr == ADDR_MASK) mask <= wdata[NLINES-1:0];
      if (addr == ADDR_CTRL) begin
        cur_level <= wdata[LVLW-1:0];
        gie       <= wdata[GIE_BIT];
      end
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_MASK: rdata = DATAW'(mask);
      ADDR_CTRL: rdata = pack_ctrl(cur_level, gie);
      ADDR_PEND: rdata = DATAW'(pend);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/intr_gate.sv
`timescale 1ns/1ps
module intr_gate
  import intr_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              ext_req,
  input  logic [LVLW-1:0]   ext_level,
  input  logic              reg_wr,
  input  logic [ADDRW-1:0]  reg_addr,
  input  logic [DATAW-1:0]  reg_wdata,
  output logic [DATAW-1:0]  reg_rdata,
  output logic [NLINES-1:0] pending,
  output logic              take_irq,
  output logic              take_ext,
  output logic [IDXW-1:0]   take_index
);
  logic [NLINES-1:0] mask_w;
  logic [LVLW-1:0]   cur_level_w;
  logic              gie_w;
  logic [IDXW-1:0]   int_idx_w;
  logic              int_any_w;
  logic              ext_ok_w;
  logic              int_ok_w;

  intr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pend(pending), .mask(mask_w), .cur_level(cur_level_w), .gie(gie_w),
    .rdata(reg_rdata)
  );

  intr_mask_unit #(.N(NLINES)) u_mask (
    .lines(irq_lines), .mask(mask_w), .pend(pending)
  );

  intr_prio_enc #(.N(NLINES), .IW(IDXW)) u_prio (
    .vec(pending), .idx(int_idx_w), .any(int_any_w)
  );

  // named decision events, visible to the bound checker
  assign ext_ok_w = gie_w & ext_req & lvl_admits(ext_level, cur_level_w);
  assign int_ok_w = gie_w & int_any_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_irq   <= 1'b0;
      take_ext   <= 1'b0;
      take_index <= '0;
    end else begin
      take_irq   <= ext_ok_w | int_ok_w;
      take_ext   <= ext_ok_w;
      take_index <= (int_ok_w && !ext_ok_w) ? int_idx_w : '0;
    end
  end
endmodule

// File: rtl/intr_gate_chk.sv
`timescale 1ns/1ps
module intr_gate_chk
  import intr_gate_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] irq_lines,
  input logic [NLINES-1:0] pending,
  input logic              ext_req,
  input logic [LVLW-1:0]   ext_level,
  input logic [LVLW-1:0]   cur_level,
  input logic              gie,
  input logic              take_irq,
  input logic              take_ext,
  input logic [IDXW-1:0]   take_index
);
  assert_pending_subset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~irq_lines) == '0);

  assert_gie_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(gie));

  assert_ext_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_ext |-> $past(ext_req && (ext_level > cur_level)));

  assert_ext_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gie && ext_req && (ext_level > cur_level)) |-> (take_ext && take_irq && take_index == '0));

  assert_index_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !take_ext) |-> ((($past(pending) >> take_index) & NLINES'(1)) != '0));

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !take_ext) |-> (($past(pending) & ((NLINES'(1) << take_index) - NLINES'(1))) == '0));
endmodule

bind intr_gate intr_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .pending(pending),
  .ext_req(ext_req), .ext_level(ext_level), .cur_level(cur_level_w), .gie(gie_w),
  .take_irq(take_irq), .take_ext(take_ext), .take_index(take_index)
);

// File: tb/intr_gate_tb.sv
`timescale 1ns/1ps
module intr_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        ext_req = 1'b0;
  logic [5:0]  ext_level = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pending;
  logic        take_irq;
  logic        take_ext;
  logic [4:0]  take_index;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_gate u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .ext_req(ext_req),
    .ext_level(ext_level), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pending(pending),
    .take_irq(take_irq), .take_ext(take_ext), .take_index(take_index)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m;
    logic [31:0] l;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // reset state
    chk("R9 take_irq after reset", 32'(take_irq), 0);
    chk("R9 take_ext after reset", 32'(take_ext), 0);
    rd(0, d); chk("R2 mask reset", d, 0);
    rd(1, d); chk("R3 ctrl reset", d, 0);
    cyc();

    // R3 unused bits and address 3
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R3 ctrl unused bits read 0", d, 32'h0000_013F);
    rd(3, d); chk("R3 address 3 reads 0", d, 0);
    cyc();
    wr(1, 32'h0);

    // R1 pending combinational, several patterns, gie off so R7 applies
    m = 32'hA5A5_0F0F;
    wr(0, m);
    for (int k = 0; k < 4; k++) begin
      l = 32'h1234_5678 * (k + 1) ^ 32'hFFFF_0000;
      irq_lines = l;
      rd(2, d);
      chk("R1 pending readback", d, l & m);
      chk("R1 pending port", pending, l & m);
      cyc();
      chk("R7 no take with gie 0", 32'(take_irq), 0);
    end
    ext_req = 1'b1; ext_level = 6'd63;
    cyc(); cyc();
    chk("R7 ext blocked with gie 0", 32'(take_irq), 0);
    ext_req = 1'b0; irq_lines = '0;

    // R4 / R9 timing: write mask with line set, pending changes only after edge
    wr(0, 32'h0);
    wr(1, 32'h100);
    irq_lines = 32'h0000_0010;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0010;
    #1;
    chk("R4 pending before edge", pending, 0);
    cyc();
    reg_wr = 1'b0;
    #1;
    chk("R4 pending after edge", pending, 32'h10);
    chk("R9 take not yet asserted", 32'(take_irq), 0);
    cyc();
    chk("R9 take one cycle later", 32'(take_irq), 1);
    chk("R6 index 4", 32'(take_index), 4);
    irq_lines = '0;
    cyc();

    // R5 full sweep of level vs request level
    for (int L = 0; L < 64; L++) begin
      wr(1, 32'h100 | 32'(L));
      for (int E = 0; E < 64; E++) begin
        ext_req = 1'b1; ext_level = 6'(E);
        cyc();
        chk($sformatf("R5 L=%0d E=%0d take", L, E), 32'(take_irq), (E > L) ? 1 : 0);
        chk($sformatf("R5 L=%0d E=%0d ext", L, E), 32'(take_ext), (E > L) ? 1 : 0);
      end
      ext_req = 1'b0;
      cyc();
      chk("R5 no request no take", 32'(take_irq), 0);
    end

    // R6 priority sweep with all lines enabled
    wr(1, 32'h13F);
    wr(0, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      irq_lines = ((32'hFFFF_FFFF << n) & (32'h5A5A_5A5A << n)) | (32'h1 << n);
      cyc();
      chk($sformatf("R6 take n=%0d", n), 32'(take_irq), 1);
      chk($sformatf("R6 index n=%0d", n), 32'(take_index), 32'(n));
      chk($sformatf("R6 not ext n=%0d", n), 32'(take_ext), 0);
    end

    // R2 mask gates each line
    for (int n = 0; n < 32; n++) begin
      m = ~(32'h1 << n);
      wr(0, m);
      irq_lines = 32'h1 << n;
      cyc();
      chk($sformatf("R2 masked line %0d", n), 32'(take_irq), 0);
      irq_lines = 32'hFFFF_FFFF;
      cyc();
      chk($sformatf("R2 lowest enabled with %0d off", n), 32'(take_index), 32'(lowest(m)));
    end

    // R8 external over internal
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h100 | 32'd10);
    irq_lines = 32'h0000_0100;
    ext_req = 1'b1; ext_level = 6'd11;
    cyc();
    chk("R8 ext wins", 32'(take_ext), 1);
    chk("R8 index zero", 32'(take_index), 0);
    ext_level = 6'd10;
    cyc();
    chk("R8 ext refused so internal", 32'(take_index), 8);
    chk("R8 ext flag low", 32'(take_ext), 0);
    irq_lines = '0;

    // R10 same-level pre-emption
    wr(1, 32'h100 | 32'd5);
    ext_level = 6'd5;
    cyc();
    chk("R10 level 5 at current 5 refused", 32'(take_irq), 0);
    wr(1, 32'h100 | 32'd4);
    cyc();
    chk("R10 level 5 at current 4 admitted", 32'(take_irq), 1);

    // R7 global enable cleared stops both paths
    irq_lines = 32'hFFFF_FFFF; ext_level = 6'd63;
    wr(1, 32'd0);
    cyc();
    chk("R7 gie 0 blocks both", 32'(take_irq), 0);
    ext_req = 1'b0; irq_lines = '0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule